// File: doc/BRIEF.md
# Multiplexed ADC Host Sequencer

This block runs an external 8-channel serial successive-approximation converter from the host side. It owns the four wires of the converter port: a combined convert/select line, a shift clock, a serial command output and a serial result input. Software-side logic hands it conversion requests on a valid/ready handshake. Each request names a channel, differential or single-ended input, bipolar or unipolar coding, use of the shared common pin, and whether the converter should sleep afterwards.

A conversion starts on the rising edge of the convert line. The converter then holds its result until the next serial frame. In that frame the sequencer reads the result in and, in the same frame, shifts out the command that selects the following conversion. Every result therefore belongs to the request accepted one frame earlier. The sequencer keeps a shadow copy of the settings it sent and uses it to tag each returned sample with the channel, input mode and number format that actually produced it.

After reset the sequencer issues one dummy conversion on its own and discards that result. A sleep request sends the sleep command and issues no conversion. Whenever the converter has been asleep or has just powered up, the sequencer waits a long, parameterized wake-up interval before it starts the next conversion.

Top module: `mux_adc_seq`

## Requirements
- R1: Each frame carries a 7-bit command on `adc_sdi`, most significant bit first, during the first 7 rising edges of `adc_sck`, and zeros on the remaining 9 edges. The bits, in order, are:
  - 1 for single-ended (0 for differential);
  - `req_chan[0]`;
  - `req_chan[2]`;
  - `req_chan[1]`;
  - the common-pin bit, equal to `req_com` for single-ended requests and forced to 0 for differential ones;
  - 1 for unipolar (0 for bipolar);
  - `req_sleep`.
- R2: A frame is exactly 16 `adc_sck` pulses. Every high phase, and every low phase between pulses, lasts SCK_HALF clocks. `adc_sck` idles low, `adc_conv` stays low for the whole frame, and the result is assembled most significant bit first from `adc_sdo` sampled at each rising edge.
- R3: After reset, one conversion is issued before any request is accepted, and its result never appears on the result outputs.
- R4: Each conversion holds `adc_conv` high for exactly CONV_CYC clocks and never drops it earlier.
- R5: At least ACQ_CYC clocks of low `adc_conv` separate the end of a frame from the next rising edge of `adc_conv`.
- R6: Results appear as one-cycle `res_valid` pulses, in order. Each carries the 16-bit value shifted in, together with the channel, differential flag and bipolar flag of the request whose conversion produced it. That request is the non-sleep request accepted just before the frame that read the value. `res_signed` is 1 exactly when that conversion was bipolar (two's complement), else 0 (straight binary).
- R7: A sleep request issues no conversion. After the dummy conversion, or after a sleep request, the next conversion starts no sooner than WAKE_CYC + ACQ_CYC clocks after the end of the frame that follows.
- R8: A request is accepted only on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low during frames, conversions, acquisition and wake-up waits, and falls on the clock after each acceptance.
- R9: While reset is held, `adc_conv`, `adc_sck`, `adc_sdi`, `req_ready` and `res_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid is high |
| req_chan | input | 3 | Channel number (odd member picks the positive side of a differential pair) |
| req_diff | input | 1 | 1 selects a differential pair |
| req_bipolar | input | 1 | 1 selects bipolar (two's complement) coding |
| req_com | input | 1 | 1 references single-ended input to the shared common pin |
| req_sleep | input | 1 | 1 puts the converter to sleep after this frame |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Converted value |
| res_chan | output | 3 | Channel tag of the result |
| res_diff | output | 1 | Differential tag of the result |
| res_signed | output | 1 | 1 when the value is two's complement |
| adc_conv | output | 1 | Convert start / serial port select |
| adc_sck | output | 1 | Serial shift clock |
| adc_sdi | output | 1 | Serial command to the converter |
| adc_sdo | input | 1 | Serial result from the converter |

## Verification
The bound assertions watch the pin-level rules on every clock: the convert pulse width, the quiet acquisition gap before each rising edge, no shift clock while convert is high, `adc_sdi` held steady through each high phase of `adc_sck`, and the ready signal staying low while the port is busy. The bench attaches a behavioural converter model that decodes each command, returns fresh random data per conversion and tracks sleep and wake-up. Only those scenarios can show the one-frame pipeline tagging, the discarded power-up result, the suppressed conversion after a sleep command and the wake-up delay measured across a release frame.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int CFG_BITS = 7;

    typedef enum logic [2:0] {
        ST_ACQ,
        ST_CONV,
        ST_IDLE,
        ST_FRAME,
        ST_WAKE
    } st_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       diff;
        logic       bipolar;
        logic       com;
        logic       sleep;
    } req_t;

    typedef struct packed {
        logic [2:0] chan;
        logic       diff;
        logic       bipolar;
    } tag_t;

endpackage

// File: rtl/mseq_cfg_pack.sv
module mseq_cfg_pack
    import mseq_pkg::*;
(
    input  req_t                req,
    output logic [CFG_BITS-1:0] word
);

    always_comb begin
        // order is decoded by the converter: sgl, odd, sel1, sel0, com, uni, slp
        word = {~req.diff,
                req.chan[0],
                req.chan[2],
                req.chan[1],
                req.com & ~req.diff,
                ~req.bipolar,
                req.sleep};
    end

endmodule

// File: rtl/mseq_serial.sv
module mseq_serial #(
    parameter int RES_W    = 16,
    parameter int CFG_W    = 7,
    parameter int SCK_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sdo,
    output logic             sck,
    output logic             sdi,
    output logic             done,
    output logic [RES_W-1:0] rx
);

    localparam int HW  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BW  = $clog2(RES_W);
    localparam int PAD = RES_W - CFG_W;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [HW-1:0]    hcnt;
        logic [BW-1:0]    bcnt;
        logic [RES_W-1:0] tx;
        logic [RES_W-1:0] rx;
        logic             done;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.sck    = 1'b0;
                d.hcnt   = '0;
                d.bcnt   = '0;
                d.tx     = {cfg_word, {PAD{1'b0}}};
            end
        end else if (q.hcnt == HW'(SCK_HALF - 1)) begin
            d.hcnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[RES_W-2:0], sdo};
            end else begin
                d.sck = 1'b0;
                if (q.bcnt == BW'(RES_W - 1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                    d.tx     = '0;
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                    d.tx   = {q.tx[RES_W-2:0], 1'b0};
                end
            end
        end else begin
            d.hcnt = q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck  = q.sck;
    assign sdi  = q.tx[RES_W-1];
    assign done = q.done;
    assign rx   = q.rx;

endmodule

// File: rtl/mux_adc_seq.sv
module mux_adc_seq
    import mseq_pkg::*;
#(
    parameter int RES_W    = 16,
    parameter int SCK_HALF = 4,
    parameter int CONV_CYC = 450,
    parameter int ACQ_CYC  = 188,
    parameter int WAKE_CYC = 7_500_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_chan,
    input  logic             req_diff,
    input  logic             req_bipolar,
    input  logic             req_com,
    input  logic             req_sleep,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [2:0]       res_chan,
    output logic             res_diff,
    output logic             res_signed,
    output logic             adc_conv,
    output logic             adc_sck,
    output logic             adc_sdi,
    input  logic             adc_sdo
);

    localparam int M1      = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
    localparam int CNT_MAX = (WAKE_CYC > M1) ? WAKE_CYC : M1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic             conv;
        logic             sh_vld;
        logic             sh_dump;
        tag_t             sh_tag;
        logic             wake_pend;
        tag_t             cur_tag;
        logic             cur_sleep;
        logic             res_vld;
        logic [RES_W-1:0] res_data;
        tag_t             res_tag;
    } ctl_t;

    // the dummy conversion is the first job: its result is marked for discard
    localparam ctl_t CTL_RST = '{
        st:        ST_ACQ,
        cnt:       '0,
        conv:      1'b0,
        sh_vld:    1'b1,
        sh_dump:   1'b1,
        sh_tag:    '0,
        wake_pend: 1'b1,
        cur_tag:   '0,
        cur_sleep: 1'b0,
        res_vld:   1'b0,
        res_data:  '0,
        res_tag:   '0
    };

    ctl_t q, d;

    req_t                req_in;
    logic [CFG_BITS-1:0] cfg_word;
    logic                eng_start;
    logic                eng_done;
    logic [RES_W-1:0]    eng_rx;

    assign req_in = '{chan: req_chan, diff: req_diff, bipolar: req_bipolar,
                      com: req_com, sleep: req_sleep};

    mseq_cfg_pack u_pack (
        .req  (req_in),
        .word (cfg_word)
    );

    assign eng_start = (q.st == ST_IDLE) && req_valid;

    mseq_serial #(
        .RES_W    (RES_W),
        .CFG_W    (CFG_BITS),
        .SCK_HALF (SCK_HALF)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .cfg_word (cfg_word),
        .sdo      (adc_sdo),
        .sck      (adc_sck),
        .sdi      (adc_sdi),
        .done     (eng_done),
        .rx       (eng_rx)
    );

    always_comb begin
        d         = q;
        d.res_vld = 1'b0;
        unique case (q.st)
            ST_ACQ: begin
                if (q.cnt == CNT_W'(ACQ_CYC - 1)) begin
                    d.cnt  = '0;
                    d.conv = 1'b1;
                    d.st   = ST_CONV;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (q.cnt == CNT_W'(CONV_CYC - 1)) begin
                    d.cnt  = '0;
                    d.conv = 1'b0;
                    d.st   = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    d.cur_tag   = '{chan: req_chan, diff: req_diff, bipolar: req_bipolar};
                    d.cur_sleep = req_sleep;
                    d.st        = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (eng_done) begin
                    d.res_vld  = q.sh_vld && !q.sh_dump;
                    d.res_data = eng_rx;
                    d.res_tag  = q.sh_tag;
                    d.cnt      = '0;
                    if (q.cur_sleep) begin
                        d.sh_vld    = 1'b0;
                        d.wake_pend = 1'b1;
                        d.st        = ST_IDLE;
                    end else begin
                        d.sh_vld    = 1'b1;
                        d.sh_dump   = 1'b0;
                        d.sh_tag    = q.cur_tag;
                        d.wake_pend = 1'b0;
                        d.st        = q.wake_pend ? ST_WAKE : ST_ACQ;
                    end
                end
            end
            ST_WAKE: begin
                if (q.cnt == CNT_W'(WAKE_CYC - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_ACQ;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign adc_conv   = q.conv;
    assign res_valid  = q.res_vld;
    assign res_data   = q.res_data;
    assign res_chan   = q.res_tag.chan;
    assign res_diff   = q.res_tag.diff;
    assign res_signed = q.res_tag.bipolar;

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
    parameter int CONV_CYC = 450,
    parameter int ACQ_CYC  = 188
) (
    input logic clk,
    input logic rst_n,
    input logic conv,
    input logic sck,
    input logic sdi,
    input logic ready,
    input logic res_valid
);

    logic [31:0] hi_cnt;
    logic [31:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= conv ? hi_cnt + 1 : '0;
            lo_cnt <= (conv || sck) ? '0 : lo_cnt + 1;
        end
    end

    a_r4_conv_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv) |-> hi_cnt >= CONV_CYC);

    a_r5_acq_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv) |-> lo_cnt >= ACQ_CYC);

    a_r2_no_sck_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !conv);

    a_r2_sdi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(sdi));

    a_r8_busy_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv |-> !ready);

    a_r8_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !sck);

    a_r6_result_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!conv && !sck));

endmodule

bind mux_adc_seq mseq_checker #(
    .CONV_CYC (CONV_CYC),
    .ACQ_CYC  (ACQ_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv      (adc_conv),
    .sck       (adc_sck),
    .sdi       (adc_sdi),
    .ready     (req_ready),
    .res_valid (res_valid)
);

// File: tb/mux_adc_seq_test.sv
module mux_adc_seq_test;

    localparam int SH = 4;
    localparam int CV = 40;
    localparam int AQ = 20;
    localparam int WK = 500;
    localparam int RW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [2:0]    req_chan = '0;
    logic          req_diff = 1'b0, req_bipolar = 1'b0, req_com = 1'b0, req_sleep = 1'b0;
    wire           req_ready, res_valid, res_diff, res_signed;
    wire  [RW-1:0] res_data;
    wire  [2:0]    res_chan;
    wire           adc_conv, adc_sck, adc_sdi, adc_sdo;
    logic [15:0]   out_sh = '0;
    assign adc_sdo = out_sh[15];

    mux_adc_seq #(.RES_W(RW), .SCK_HALF(SH), .CONV_CYC(CV), .ACQ_CYC(AQ), .WAKE_CYC(WK)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_diff(req_diff), .req_bipolar(req_bipolar),
        .req_com(req_com), .req_sleep(req_sleep), .res_valid(res_valid),
        .res_data(res_data), .res_chan(res_chan), .res_diff(res_diff),
        .res_signed(res_signed), .adc_conv(adc_conv), .adc_sck(adc_sck),
        .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
    );

    typedef struct {logic [2:0] ch; logic diff, bip, com, slp;} breq_t;
    typedef struct {logic [15:0] data; breq_t r;} bexp_t;

    breq_t reqs[$];
    bexp_t expq[$];
    int checks = 0, errors = 0, cyc = 0, recv = 0, bad8 = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] enc(breq_t r);
        return {~r.diff, r.ch[0], r.ch[2], r.ch[1], r.com & ~r.diff, ~r.bip, r.slp};
    endfunction

    always @(negedge clk) cyc++;

    // behavioural converter model
    int fbits = 0, fidx = 0, last_rise = 0, last_fall = 0, last_frame_end = 0;
    int conv_idx = 0, conv_t = 0, release_t = 0;
    logic [15:0] fin = '0, cur_data = '0;
    breq_t cur_req, last_frame_req;
    bit phase_bad = 0, conv_in_frame = 0, cur_dummy = 0, loaded = 0;
    bit asleep = 0, need_wake = 0, wake_armed = 0;

    always @(posedge adc_conv) if (rst_n) begin
        conv_idx++;
        if (conv_idx == 1) begin
            chk(reqs.size() == 0, "R3", "dummy conversion before any request", reqs.size(), 0);
            cur_dummy = 1;
            need_wake = 1;
        end else begin
            chk(cyc - last_frame_end >= AQ, "R5", "acquisition gap", cyc - last_frame_end, AQ);
            chk(!asleep, "R7", "conversion while asleep", asleep, 0);
            if (wake_armed) begin
                chk(cyc - release_t >= WK + AQ, "R7", "wake-up wait", cyc - release_t, WK + AQ);
                wake_armed = 0;
            end
            cur_dummy = 0;
            cur_req = last_frame_req;
        end
        cur_data = 16'($urandom);
        conv_t = cyc;
    end

    always @(negedge adc_conv) if (rst_n) begin
        chk(cyc - conv_t == CV, "R4", "convert high width", cyc - conv_t, CV);
        out_sh = cur_data;
        loaded = 1;
    end

    always @(posedge adc_sck) if (rst_n) begin
        if (adc_conv) conv_in_frame = 1;
        if (fbits > 0 && cyc - last_fall != SH) phase_bad = 1;
        last_rise = cyc;
        fin = {fin[14:0], adc_sdi};
        fbits++;
    end

    always @(negedge adc_sck) if (rst_n) begin
        breq_t r;
        if (cyc - last_rise != SH) phase_bad = 1;
        last_fall = cyc;
        out_sh = out_sh << 1;
        if (fbits == 16) begin
            if (fidx < reqs.size()) begin
                r = reqs[fidx];
            end else begin
                r = '{ch: 3'd0, diff: 1'b0, bip: 1'b0, com: 1'b0, slp: 1'b0};
                chk(0, "R8", "frame without accepted request", fidx, reqs.size());
            end
            chk(fin[15:9] == enc(r), "R1", "command bits", fin[15:9], enc(r));
            chk(fin[8:0] == 9'd0, "R1", "trailing command bits", fin[8:0], 0);
            chk(!phase_bad && !conv_in_frame, "R2", "shift clock phases / convert low",
                {phase_bad, conv_in_frame}, 0);
            if (loaded && !cur_dummy) expq.push_back('{data: cur_data, r: cur_req});
            loaded = 0;
            if (r.slp) begin
                asleep = 1;
                need_wake = 1;
            end else begin
                asleep = 0;
                if (need_wake) begin
                    wake_armed = 1;
                    release_t = cyc;
                    need_wake = 0;
                end
            end
            last_frame_req = r;
            last_frame_end = cyc;
            fidx++;
            fbits = 0;
            phase_bad = 0;
            conv_in_frame = 0;
        end
    end

    // result and handshake monitor
    always @(negedge clk) if (rst_n) begin
        if (req_ready && (adc_conv || adc_sck)) bad8++;
        if (res_valid) begin
            recv++;
            if (expq.size() == 0) begin
                chk(0, "R6", "unexpected result", res_data, 0);
            end else begin
                bexp_t e;
                e = expq.pop_front();
                chk(res_data == e.data, "R6", "result data", res_data, e.data);
                chk({res_chan, res_diff, res_signed} == {e.r.ch, e.r.diff, e.r.bip}, "R6",
                    "result tag", {res_chan, res_diff, res_signed}, {e.r.ch, e.r.diff, e.r.bip});
            end
        end
    end

    task automatic send(breq_t r);
        repeat ($urandom % 25) @(negedge clk);
        req_chan = r.ch; req_diff = r.diff; req_bipolar = r.bip; req_com = r.com; req_sleep = r.slp;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        reqs.push_back(r);
        chk(!req_ready, "R8", "ready falls after accept", req_ready, 0);
    endtask

    function automatic breq_t mk(logic [2:0] ch, logic diff, logic bip, logic com, logic slp);
        breq_t r;
        r.ch = ch; r.diff = diff; r.bip = bip; r.com = com; r.slp = slp;
        return r;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int seed;
        int exp_res;
        int nonsleep;
        seed = $urandom(32'd7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({adc_conv, adc_sck, adc_sdi, req_ready, res_valid} == 5'b0, "R9",
                "outputs under reset", {adc_conv, adc_sck, adc_sdi, req_ready, res_valid}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R3", "busy with dummy after reset", req_ready, 0);

        send(mk(3'd7, 1'b0, 1'b1, 1'b0, 1'b0));
        send(mk(3'd3, 1'b1, 1'b0, 1'b1, 1'b0));
        send(mk(3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        send(mk(3'd2, 1'b0, 1'b1, 1'b0, 1'b1));
        send(mk(3'd4, 1'b1, 1'b1, 1'b0, 1'b1));
        send(mk(3'd5, 1'b1, 1'b1, 1'b0, 1'b0));
        send(mk(3'd6, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 30; i++) begin
            send(mk(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 8) == 0));
        end
        send(mk(3'd1, 1'b0, 1'b1, 1'b0, 1'b0));
        repeat (WK + AQ + CV + 200) @(negedge clk);

        exp_res = 0;
        nonsleep = 0;
        for (int i = 0; i < reqs.size(); i++) begin
            if (!reqs[i].slp) nonsleep++;
            if (i < reqs.size() - 1 && !reqs[i].slp) exp_res++;
        end
        chk(recv == exp_res, "R6", "result count", recv, exp_res);
        chk(expq.size() == 0, "R6", "results left unreturned", expq.size(), 0);
        chk(conv_idx == nonsleep + 1, "R7", "conversions (dummy + non-sleep)", conv_idx, nonsleep + 1);
        chk(bad8 == 0, "R8", "ready while port busy", bad8, 0);
        chk(fidx == reqs.size(), "R8", "one frame per accepted request", fidx, reqs.size());
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule